// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block is the control state machine that carries out a single requested change of a chip's lifecycle state. After reset it settles in an idle state and waits. When a transition request arrives it walks a fixed chain of steps: it switches the clock source, increments the transition counter and waits for the counter to be programmed, checks that the requested transition is legal, and has the unlock token hashed. If the target is the RMA state it then starts an erase and waits for it. It compares the token in two stages and finally programs the new state. Every failure along the way ends the sequence early in the post-transition state, and the requester sees an acknowledge with an error flag.

The storage, hashing and erase engines sit outside the block. Each one is driven by a request strobe that is high while the machine is in the matching state, and answers with a done pulse and, where it can fail, a fail flag that is sampled together with done. The counter-status, legality and token-match inputs are single-cycle decisions taken in their own states. Two independent escalation inputs override everything and send the machine to a terminal escalate state. An idle-time scrap request sends it to a terminal scrap state. The post-transition, scrap and escalate states are left only through reset. A state code outside the fifteen legal codes leads to an invalid state, and only escalation leaves that state.

Top module: `ltx_seq`

## Requirements
- R1: `state_o` shows the state code: reset 0x00, idle 0x03, clock switch 0x05, counter increment 0x06, counter program 0x09, legality check 0x0A, token hash 0x0C, erase 0x0F, token check A 0x11, token check B 0x12, state program 0x14, post-transition 0x17, scrap 0x18, escalate 0x1B, invalid 0x1D. While `rst_ni` is low the code is 0x00 and every strobe, `xfer_ack_o` and `xfer_err_o` are low. The first rising edge after release moves the machine to idle.
- R2: Idle holds until a request is seen. If `scrap_req_i` is high the machine goes to scrap, and this wins over `xfer_req_i`. If only `xfer_req_i` is high it goes to clock switch. Clock switch always moves to counter increment on the next edge.
- R3: Counter increment goes to post-transition if `cnt_full_i` or `cnt_err_i` is high. Otherwise it goes to counter program.
- R4: Counter program, token hash, erase and state program each hold until their done input (`cnt_done_i`, `hash_done_i`, `erase_done_i`, `prog_done_i`) is high. Done with the matching fail flag high goes to post-transition. Done without the fail flag moves on: counter program goes to legality check; token hash goes to erase when `xfer_rma_i` is high and to token check A otherwise; erase goes to token check A; state program goes to post-transition.
- R5: Legality check goes to token hash when `legal_i` is high, and to post-transition when it is low.
- R6: Token check A goes to token check B when `tok0_ok_i` is high, and to post-transition when it is low. Token check B goes to state program when `tok1_ok_i` is high, and to post-transition when it is low. Neither check state ever stays in place.
- R7: `xfer_ack_o` is high exactly while the machine is in post-transition. `xfer_err_o` is high with it unless post-transition was entered from state program with done high and fail low. Outside post-transition both are low.
- R8: Each of `clk_sw_o`, `cnt_inc_o`, `cnt_prog_o`, `hash_req_o`, `erase_req_o` and `prog_req_o` is high exactly while the machine is in clock switch, counter increment, counter program, token hash, erase or state program respectively.
- R9: Post-transition and scrap are terminal. Every input other than escalation is ignored there, and the state, acknowledge and error flag do not change.
- R10: If `esc0_i` or `esc1_i` is high at a rising edge, the machine enters escalate on that edge from any state, including reset, post-transition and scrap. Escalate then stays until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xfer_req_i | input | 1 | Transition request |
| xfer_rma_i | input | 1 | Requested target is RMA |
| scrap_req_i | input | 1 | Scrap request, taken in idle |
| esc0_i | input | 1 | Escalation input 0 |
| esc1_i | input | 1 | Escalation input 1 |
| cnt_full_i | input | 1 | Transition counter exhausted |
| cnt_err_i | input | 1 | Transition counter in error |
| cnt_done_i | input | 1 | Counter programming done |
| cnt_fail_i | input | 1 | Counter programming failed, valid with done |
| legal_i | input | 1 | Requested transition is legal |
| hash_done_i | input | 1 | Token hash done |
| hash_fail_i | input | 1 | Token hash failed, valid with done |
| erase_done_i | input | 1 | Erase done |
| tok0_ok_i | input | 1 | First token comparison matches |
| tok1_ok_i | input | 1 | Second token comparison matches |
| prog_done_i | input | 1 | State programming done |
| prog_fail_i | input | 1 | State programming failed, valid with done |
| clk_sw_o | output | 1 | Clock source switch strobe |
| cnt_inc_o | output | 1 | Counter increment strobe |
| cnt_prog_o | output | 1 | Counter programming request |
| hash_req_o | output | 1 | Token hash request |
| erase_req_o | output | 1 | Erase request |
| prog_req_o | output | 1 | State programming request |
| xfer_ack_o | output | 1 | Transition finished |
| xfer_err_o | output | 1 | Transition finished with error |
| state_o | output | 5 | Current state code |

## Verification
Every decision input is sampled at the rising edge that ends the current state. The new state code, its strobe, and the acknowledge and error flag all appear right after that same edge, so each result is due exactly one edge after the stimulus. The bench drives inputs at the falling edge, lets one rising edge pass, and compares the outputs at the next falling edge against its own expected state. That expected state is advanced from the requirement rules using the same stimulus. Done responses are delayed by zero to two cycles to show that the handshake states hold. Escalation is injected at every cycle position of a full RMA run, so each state's escape to escalate is covered.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

  localparam int unsigned StateW = 5;

  typedef enum logic [StateW-1:0] {
    ST_RST     = 5'h00,
    ST_IDLE    = 5'h03,
    ST_CLKSW   = 5'h05,
    ST_CNTINC  = 5'h06,
    ST_CNTPRG  = 5'h09,
    ST_LEGAL   = 5'h0A,
    ST_HASH    = 5'h0C,
    ST_ERASE   = 5'h0F,
    ST_TOK0    = 5'h11,
    ST_TOK1    = 5'h12,
    ST_PROG    = 5'h14,
    ST_POST    = 5'h17,
    ST_SCRAP   = 5'h18,
    ST_ESC     = 5'h1B,
    ST_INVALID = 5'h1D
  } ltx_state_e;

  localparam int unsigned NumStrobes = 6;

endpackage

// File: rtl/ltx_next_state.sv
module ltx_next_state
  import ltx_pkg::*;
(
  input  ltx_state_e state_i,
  input  logic       esc_i,
  input  logic       xfer_req_i,
  input  logic       xfer_rma_i,
  input  logic       scrap_req_i,
  input  logic       cnt_full_i,
  input  logic       cnt_err_i,
  input  logic       cnt_done_i,
  input  logic       cnt_fail_i,
  input  logic       legal_i,
  input  logic       hash_done_i,
  input  logic       hash_fail_i,
  input  logic       erase_done_i,
  input  logic       tok0_ok_i,
  input  logic       tok1_ok_i,
  input  logic       prog_done_i,
  input  logic       prog_fail_i,
  output ltx_state_e nxt_o,
  output logic       post_ok_o
);

  always_comb begin
    nxt_o = state_i;
    if (esc_i) begin
      nxt_o = ST_ESC;
    end else begin
      case (state_i)
        ST_RST:    nxt_o = ST_IDLE;
        ST_IDLE: begin
          if (scrap_req_i)     nxt_o = ST_SCRAP;
          else if (xfer_req_i) nxt_o = ST_CLKSW;
          else                 nxt_o = ST_IDLE;
        end
        ST_CLKSW:  nxt_o = ST_CNTINC;
        ST_CNTINC: nxt_o = (cnt_full_i || cnt_err_i) ? ST_POST : ST_CNTPRG;
        ST_CNTPRG: begin
          if (cnt_done_i) nxt_o = cnt_fail_i ? ST_POST : ST_LEGAL;
        end
        ST_LEGAL:  nxt_o = legal_i ? ST_HASH : ST_POST;
        ST_HASH: begin
          if (hash_done_i) begin
            if (hash_fail_i)     nxt_o = ST_POST;
            else if (xfer_rma_i) nxt_o = ST_ERASE;
            else                 nxt_o = ST_TOK0;
          end
        end
        ST_ERASE: begin
          if (erase_done_i) nxt_o = ST_TOK0;
        end
        ST_TOK0:   nxt_o = tok0_ok_i ? ST_TOK1 : ST_POST;
        ST_TOK1:   nxt_o = tok1_ok_i ? ST_PROG : ST_POST;
        ST_PROG: begin
          if (prog_done_i) nxt_o = ST_POST;
        end
        ST_POST:    nxt_o = ST_POST;
        ST_SCRAP:   nxt_o = ST_SCRAP;
        ST_ESC:     nxt_o = ST_ESC;
        ST_INVALID: nxt_o = ST_INVALID;
        default:    nxt_o = ST_INVALID;
      endcase
    end
  end

  assign post_ok_o = (state_i == ST_PROG) && prog_done_i && !prog_fail_i && !esc_i;

endmodule

// File: rtl/ltx_strobes.sv
module ltx_strobes
  import ltx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ltx_state_e state_i,
  output logic       clk_sw_o,
  output logic       cnt_inc_o,
  output logic       cnt_prog_o,
  output logic       hash_req_o,
  output logic       erase_req_o,
  output logic       prog_req_o
);

  localparam ltx_state_e StrobeSt [NumStrobes] = '{
    ST_CLKSW, ST_CNTINC, ST_CNTPRG, ST_HASH, ST_ERASE, ST_PROG
  };

  logic [NumStrobes-1:0] strb;

  for (genvar g = 0; g < NumStrobes; g++) begin : g_strb
    assign strb[g] = (state_i == StrobeSt[g]);
  end

  assign clk_sw_o    = strb[0];
  assign cnt_inc_o   = strb[1];
  assign cnt_prog_o  = strb[2];
  assign hash_req_o  = strb[3];
  assign erase_req_o = strb[4];
  assign prog_req_o  = strb[5];

  // R8: at most one agent is addressed at a time
  assert_one_agent_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clk_sw_o, cnt_inc_o, cnt_prog_o, hash_req_o, erase_req_o, prog_req_o}));

endmodule

// File: rtl/ltx_resp.sv
module ltx_resp
  import ltx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ltx_state_e state_i,
  input  ltx_state_e nxt_i,
  input  logic       post_ok_i,
  output logic       xfer_ack_o,
  output logic       xfer_err_o
);

  logic err_q;
  logic err_en;

  assign err_en = (nxt_i == ST_POST) && (state_i != ST_POST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= !post_ok_i;
    end
  end

  assign xfer_ack_o = (state_i == ST_POST);
  assign xfer_err_o = xfer_ack_o && err_q;

  assert_fail_flagged_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_en && !post_ok_i) |=> (xfer_ack_o && xfer_err_o));

  assert_ok_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_en && post_ok_i) |=> (xfer_ack_o && !xfer_err_o));

endmodule

// File: rtl/ltx_seq.sv
module ltx_seq
  import ltx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xfer_req_i,
  input  logic              xfer_rma_i,
  input  logic              scrap_req_i,
  input  logic              esc0_i,
  input  logic              esc1_i,
  input  logic              cnt_full_i,
  input  logic              cnt_err_i,
  input  logic              cnt_done_i,
  input  logic              cnt_fail_i,
  input  logic              legal_i,
  input  logic              hash_done_i,
  input  logic              hash_fail_i,
  input  logic              erase_done_i,
  input  logic              tok0_ok_i,
  input  logic              tok1_ok_i,
  input  logic              prog_done_i,
  input  logic              prog_fail_i,
  output logic              clk_sw_o,
  output logic              cnt_inc_o,
  output logic              cnt_prog_o,
  output logic              hash_req_o,
  output logic              erase_req_o,
  output logic              prog_req_o,
  output logic              xfer_ack_o,
  output logic              xfer_err_o,
  output logic [StateW-1:0] state_o
);

  ltx_state_e state_q;
  ltx_state_e state_d;
  logic       esc;
  logic       post_ok;

  assign esc = esc0_i || esc1_i;

  ltx_next_state u_next (
    .state_i      (state_q),
    .esc_i        (esc),
    .xfer_req_i   (xfer_req_i),
    .xfer_rma_i   (xfer_rma_i),
    .scrap_req_i  (scrap_req_i),
    .cnt_full_i   (cnt_full_i),
    .cnt_err_i    (cnt_err_i),
    .cnt_done_i   (cnt_done_i),
    .cnt_fail_i   (cnt_fail_i),
    .legal_i      (legal_i),
    .hash_done_i  (hash_done_i),
    .hash_fail_i  (hash_fail_i),
    .erase_done_i (erase_done_i),
    .tok0_ok_i    (tok0_ok_i),
    .tok1_ok_i    (tok1_ok_i),
    .prog_done_i  (prog_done_i),
    .prog_fail_i  (prog_fail_i),
    .nxt_o        (state_d),
    .post_ok_o    (post_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RST;
    end else begin
      state_q <= state_d;
    end
  end

  ltx_strobes u_strobes (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state_q),
    .clk_sw_o    (clk_sw_o),
    .cnt_inc_o   (cnt_inc_o),
    .cnt_prog_o  (cnt_prog_o),
    .hash_req_o  (hash_req_o),
    .erase_req_o (erase_req_o),
    .prog_req_o  (prog_req_o)
  );

  ltx_resp u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state_q),
    .nxt_i      (state_d),
    .post_ok_i  (post_ok),
    .xfer_ack_o (xfer_ack_o),
    .xfer_err_o (xfer_err_o)
  );

  assign state_o = state_q;

  assert_rst_to_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RST && !esc) |=> (state_q == ST_IDLE));

  assert_clksw_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLKSW && !esc) |=> (state_q == ST_CNTINC));

  assert_cnt_exhaust_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CNTINC && !esc && (cnt_full_i || cnt_err_i)) |=> (state_q == ST_POST));

  assert_wait_cnt_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CNTPRG && !esc && !cnt_done_i) |=> (state_q == ST_CNTPRG));

  assert_wait_prog_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && !esc && !prog_done_i) |=> (state_q == ST_PROG));

  assert_illegal_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LEGAL && !esc && !legal_i) |=> (state_q == ST_POST));

  assert_tok0_moves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TOK0) |=> (state_q != ST_TOK0));

  assert_tok1_moves_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TOK1) |=> (state_q != ST_TOK1));

  assert_terminal_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_POST || state_q == ST_SCRAP) && !esc) |=> $stable(state_q));

  assert_esc_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc |=> (state_q == ST_ESC));

  assert_esc_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ESC) |=> (state_q == ST_ESC));

endmodule

// File: tb/ltx_seq_bench.sv
`timescale 1ns/1ps
module ltx_seq_bench;

  localparam logic [4:0] C_RST = 5'h00, C_IDLE = 5'h03, C_CLKSW = 5'h05, C_CNTINC = 5'h06,
                         C_CNTPRG = 5'h09, C_LEGAL = 5'h0A, C_HASH = 5'h0C, C_ERASE = 5'h0F,
                         C_TOK0 = 5'h11, C_TOK1 = 5'h12, C_PROG = 5'h14, C_POST = 5'h17,
                         C_SCRAP = 5'h18, C_ESC = 5'h1B;

  logic clk, rst_n;
  logic xfer_req, xfer_rma, scrap_req, esc0, esc1;
  logic cnt_full, cnt_err, cnt_done, cnt_fail, legal;
  logic hash_done, hash_fail, erase_done, tok0_ok, tok1_ok, prog_done, prog_fail;
  logic clk_sw, cnt_inc, cnt_prog, hash_req, erase_req, prog_req, ack, err;
  logic [4:0] state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  ltx_seq u_ltx_seq (
    .clk_i(clk), .rst_ni(rst_n), .xfer_req_i(xfer_req), .xfer_rma_i(xfer_rma),
    .scrap_req_i(scrap_req), .esc0_i(esc0), .esc1_i(esc1), .cnt_full_i(cnt_full),
    .cnt_err_i(cnt_err), .cnt_done_i(cnt_done), .cnt_fail_i(cnt_fail), .legal_i(legal),
    .hash_done_i(hash_done), .hash_fail_i(hash_fail), .erase_done_i(erase_done),
    .tok0_ok_i(tok0_ok), .tok1_ok_i(tok1_ok), .prog_done_i(prog_done),
    .prog_fail_i(prog_fail), .clk_sw_o(clk_sw), .cnt_inc_o(cnt_inc),
    .cnt_prog_o(cnt_prog), .hash_req_o(hash_req), .erase_req_o(erase_req),
    .prog_req_o(prog_req), .xfer_ack_o(ack), .xfer_err_o(err), .state_o(state)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] p, input bit e);
    if (e) return "R10";
    case (p)
      C_RST:                            return "R1";
      C_IDLE, C_CLKSW:                  return "R2";
      C_CNTINC:                         return "R3";
      C_CNTPRG, C_HASH, C_ERASE, C_PROG: return "R4";
      C_LEGAL:                          return "R5";
      C_TOK0, C_TOK1:                   return "R6";
      C_ESC:                            return "R10";
      default:                          return "R9";
    endcase
  endfunction

  function automatic logic [5:0] strobes_of(input logic [4:0] s);
    return {s == C_CLKSW, s == C_CNTINC, s == C_CNTPRG, s == C_HASH, s == C_ERASE, s == C_PROG};
  endfunction

  task automatic clear_inputs();
    {xfer_req, xfer_rma, scrap_req, esc0, esc1, cnt_full, cnt_err, cnt_done, cnt_fail} = '0;
    {legal, hash_done, hash_fail, erase_done, tok0_ok, tok1_ok, prog_done, prog_fail} = '0;
  endtask

  // fp: 0 success, 1 counter full, 2 counter error, 3 counter program fail,
  // 4 illegal, 5 hash fail, 6 token A mismatch, 7 token B mismatch, 8 program fail, 9 scrap
  task automatic run_case(input int fp, input bit rma, input int dly, input int esc_at, input int sel);
    logic [4:0] exp_s, nxt, prev_s;
    bit exp_err, esc_prev, e;
    int w, term;
    clear_inputs();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(state == C_RST, "R1", "reset state", {3'b0, state}, {3'b0, C_RST});
    check({clk_sw, cnt_inc, cnt_prog, hash_req, erase_req, prog_req, ack, err} == 8'h00,
          "R1", "reset outputs",
          {clk_sw, cnt_inc, cnt_prog, hash_req, erase_req, prog_req, ack, err}, 8'h00);
    rst_n = 1'b1;
    exp_s = C_RST; prev_s = C_RST; exp_err = 0; esc_prev = 0; w = 0; term = 0;
    for (int cyc = 0; cyc < 80; cyc++) begin
      check(state == exp_s, tag_of(prev_s, esc_prev), "state", {3'b0, state}, {3'b0, exp_s});
      check(ack == (exp_s == C_POST) && err == (exp_s == C_POST && exp_err), "R7", "ack/err",
            {6'b0, ack, err}, {6'b0, exp_s == C_POST, exp_s == C_POST && exp_err});
      check({clk_sw, cnt_inc, cnt_prog, hash_req, erase_req, prog_req} == strobes_of(exp_s), "R8",
            "strobes", {2'b0, clk_sw, cnt_inc, cnt_prog, hash_req, erase_req, prog_req},
            {2'b0, strobes_of(exp_s)});
      if (exp_s == C_POST || exp_s == C_SCRAP || exp_s == C_ESC) begin
        term++;
        if (term > 3) break;
      end
      clear_inputs();
      xfer_rma = rma;
      e = (esc_at >= 0) && (cyc >= esc_at);
      esc0 = e && (sel == 0);
      esc1 = e && (sel == 1);
      case (exp_s)
        C_IDLE: if (w >= dly) begin scrap_req = (fp == 9); xfer_req = 1'b1; end
        C_CNTINC: begin cnt_full = (fp == 1); cnt_err = (fp == 2); end
        C_CNTPRG: begin cnt_done = (w >= dly); cnt_fail = (fp == 3); end
        C_LEGAL: legal = (fp != 4);
        C_HASH: begin hash_done = (w >= dly); hash_fail = (fp == 5); end
        C_ERASE: erase_done = (w >= dly);
        C_TOK0: tok0_ok = (fp != 6);
        C_TOK1: tok1_ok = (fp != 7);
        C_PROG: begin prog_done = (w >= dly); prog_fail = (fp == 8); end
        C_POST, C_SCRAP, C_ESC: begin
          {xfer_req, scrap_req, cnt_full, cnt_err, cnt_done, cnt_fail, legal} = '1;
          {hash_done, hash_fail, erase_done, tok0_ok, tok1_ok, prog_done, prog_fail} = '1;
          xfer_rma = ~rma;
        end
        default: ;
      endcase
      nxt = exp_s;
      if (e) nxt = C_ESC;
      else case (exp_s)
        C_RST:    nxt = C_IDLE;
        C_IDLE:   nxt = scrap_req ? C_SCRAP : (xfer_req ? C_CLKSW : C_IDLE);
        C_CLKSW:  nxt = C_CNTINC;
        C_CNTINC: nxt = (cnt_full || cnt_err) ? C_POST : C_CNTPRG;
        C_CNTPRG: if (cnt_done) nxt = cnt_fail ? C_POST : C_LEGAL;
        C_LEGAL:  nxt = legal ? C_HASH : C_POST;
        C_HASH:   if (hash_done) nxt = hash_fail ? C_POST : (rma ? C_ERASE : C_TOK0);
        C_ERASE:  if (erase_done) nxt = C_TOK0;
        C_TOK0:   nxt = tok0_ok ? C_TOK1 : C_POST;
        C_TOK1:   nxt = tok1_ok ? C_PROG : C_POST;
        C_PROG:   if (prog_done) nxt = C_POST;
        default:  nxt = exp_s;
      endcase
      if (nxt == C_POST && exp_s != C_POST)
        exp_err = !(exp_s == C_PROG && prog_done && !prog_fail);
      w = (nxt == exp_s) ? w + 1 : 0;
      prev_s = exp_s;
      esc_prev = e;
      exp_s = nxt;
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    clear_inputs();
    @(negedge clk);
    for (int fp = 0; fp < 10; fp++)
      for (int r = 0; r < 2; r++)
        for (int d = 0; d < 3; d += 2)
          run_case(fp, r[0], d, -1, 0);
    for (int s = 0; s < 2; s++)
      for (int at = 0; at < 22; at++)
        run_case(0, 1'b1, 1, at, s);
    run_case(9, 1'b0, 0, 4, 1);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule